// File: doc/BRIEF.md
# LED String Fault Supervisor

This block is the digital supervisor for a multi-string LED backlight driver. For each string it receives three comparator flags: the current is at its programmed target, the string foot voltage is above the short threshold, and the string is being driven in the current dimming phase. It also receives three chip-wide flags: output overvoltage, a lower temperature warning and an upper temperature trip. It follows the health of every string, times faults in dimming periods, and drives a per-string enable mask and a boost-stop signal.

A string is trusted only after it has once conducted at target. A fault does not turn a string off at once: a pending fault has to survive a fixed number of rising edges of the dimming clock before the string is disabled, so that the short disturbances that follow a change in duty cycle do not remove healthy strings. Overvoltage or the lower temperature warning marks every string that has not yet proven itself as open. A short that expires while enough strings are already disabled shuts every string down. The upper temperature trip stops everything until the enable input is cycled.

Top module: `led_fault_mgr`

## Requirements
- R1: A string becomes good in a cycle where it is driven (pwm_on bit 1) and at target. A string that was never good and sits below target is never disabled unless a chip-wide event occurs.
- R2: A good string that is driven and below target gets a pending open fault. The pending fault clears when the string is driven at target again.
- R3: A string with a pending fault is disabled on the 6th rising edge of the dimming clock after the edge that registered the fault. After 5 such edges it is still enabled. Disabled mask bits never clear while enable stays high. Bit i of every vector is string i.
- R4: When a pending fault clears before expiry, its time-out count restarts from zero.
- R5: A cycle with overvoltage or the lower temperature warning high gives every string not yet good a pending open fault. This fault stays after the flag drops.
- R6: A driven string whose voltage flag is high gets a pending short fault. A string that is not driven gets none.
- R7: When a short fault expires while 3 or more strings were already disabled before that edge, all strings turn off and boost-stop rises. With fewer than 3 already disabled, only the expiring strings turn off.
- R8: The upper temperature flag sets the thermal status on the next edge. Boost-stop is then 1 and all enables are 0, and both stay so after the flag drops until enable goes low.
- R9: Outside a shutdown, the enable output equals the inverse of the disabled mask, so disabling one string leaves the others running.
- R10: Enable low clears all string states, counters and latched faults on the next edge. While enable is low, all string enables are 0 and boost-stop is 1.
- R11: The short status is 1 when any string was disabled by a short. The open status is 1 when any string was disabled by an open fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable; low clears all state |
| pwm_clk_i | input | 1 | Dimming clock; rising edges time faults |
| at_target_i | input | NUM_CH | Per-string current at target |
| over_short_i | input | NUM_CH | Per-string voltage above short threshold |
| pwm_on_i | input | NUM_CH | Per-string driven in this dimming phase |
| ovp_i | input | 1 | Output overvoltage |
| otp_lo_i | input | 1 | Lower temperature warning |
| otp_hi_i | input | 1 | Upper temperature trip |
| ch_en_o | output | NUM_CH | Per-string enable |
| boost_stop_o | output | 1 | Stop boost switching |
| dis_mask_o | output | NUM_CH | Strings disabled by time-out |
| short_flt_o | output | 1 | Some string disabled as short |
| open_flt_o | output | 1 | Some string disabled as open |
| therm_sd_o | output | 1 | Upper temperature shutdown latched |

## Verification
Two short time-outs can expire on the same dimming edge, and the escalation check must count only the strings disabled before that edge. The bench first disables two strings, then gives two more strings a short at the same time. After six edges four strings are off, the other four still run, and boost-stop stays low. A second run with three strings already disabled shows that one more short expiry turns everything off.

// File: rtl/led_fm_pkg.sv
package led_fm_pkg;
  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_OPEN  = 2'd1,
    FLT_SHORT = 2'd2
  } flt_kind_e;
endpackage

// File: rtl/led_fm_edge.sv
module led_fm_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/led_fm_chan.sv
module led_fm_chan
  import led_fm_pkg::*;
#(
  parameter int unsigned TIMEOUT = 6,
  localparam int unsigned CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  logic      halt_i,
  input  logic      rise_i,
  input  logic      at_target_i,
  input  logic      over_short_i,
  input  logic      pwm_on_i,
  input  logic      force_open_i,
  output logic      dis_o,
  output flt_kind_e kind_o,
  output logic      exp_short_o
);
  logic          good_q, open_q, short_q, dis_q;
  logic [CW-1:0] cnt_q;
  flt_kind_e     kind_q;
  logic          cond_ok, live, pend, last, expire;

  assign cond_ok = pwm_on_i & at_target_i;
  assign live    = ~halt_i & ~dis_q;
  assign pend    = open_q | short_q;
  assign last    = (cnt_q == CW'(TIMEOUT - 1));
  assign expire  = live & pend & rise_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_q <= 1'b0; open_q <= 1'b0; short_q <= 1'b0;
      dis_q  <= 1'b0; cnt_q  <= '0;   kind_q  <= FLT_NONE;
    end else if (clr_i) begin
      good_q <= 1'b0; open_q <= 1'b0; short_q <= 1'b0;
      dis_q  <= 1'b0; cnt_q  <= '0;   kind_q  <= FLT_NONE;
    end else if (live) begin
      if (cond_ok) good_q <= 1'b1;
      // below target: only a proven string, or any unproven one under a global event
      if (cond_ok) open_q <= 1'b0;
      else if ((good_q & pwm_on_i) | (force_open_i & ~good_q)) open_q <= 1'b1;
      if (pwm_on_i) short_q <= over_short_i;
      if (!pend)       cnt_q <= '0;
      else if (rise_i) cnt_q <= last ? '0 : cnt_q + CW'(1);
      if (expire) begin
        dis_q  <= 1'b1;
        kind_q <= short_q ? FLT_SHORT : FLT_OPEN;
      end
    end
  end

  assign dis_o       = dis_q;
  assign kind_o      = kind_q;
  assign exp_short_o = expire & short_q;
endmodule

// File: rtl/led_fm_supervisor.sv
module led_fm_supervisor #(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned ESC_CNT = 3,
  localparam int unsigned NW = $clog2(NUM_CH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              otp_hi_i,
  input  logic [NUM_CH-1:0] exp_short_i,
  input  logic [NUM_CH-1:0] dis_mask_i,
  output logic              therm_o,
  output logic              all_off_o
);
  localparam logic [NW-1:0] ESC_W = NW'(ESC_CNT);
  logic [NW-1:0] n_dis;
  logic          therm_q, all_off_q;

  always_comb begin
    n_dis = '0;
    for (int i = 0; i < NUM_CH; i++) n_dis = n_dis + NW'(dis_mask_i[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      therm_q <= 1'b0; all_off_q <= 1'b0;
    end else if (clr_i) begin
      therm_q <= 1'b0; all_off_q <= 1'b0;
    end else begin
      if (otp_hi_i) therm_q <= 1'b1;
      if ((|exp_short_i) && (n_dis >= ESC_W)) all_off_q <= 1'b1;
    end
  end

  assign therm_o   = therm_q;
  assign all_off_o = all_off_q;
endmodule

// File: rtl/led_fault_mgr.sv
module led_fault_mgr
  import led_fm_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned TIMEOUT = 6,
  parameter int unsigned ESC_CNT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              pwm_clk_i,
  input  logic [NUM_CH-1:0] at_target_i,
  input  logic [NUM_CH-1:0] over_short_i,
  input  logic [NUM_CH-1:0] pwm_on_i,
  input  logic              ovp_i,
  input  logic              otp_lo_i,
  input  logic              otp_hi_i,
  output logic [NUM_CH-1:0] ch_en_o,
  output logic              boost_stop_o,
  output logic [NUM_CH-1:0] dis_mask_o,
  output logic              short_flt_o,
  output logic              open_flt_o,
  output logic              therm_sd_o
);
  logic              rise, clr, halt, therm, all_off, force_open;
  logic [NUM_CH-1:0] dis, exp_short, is_short, is_open;
  flt_kind_e         kind [NUM_CH];

  assign clr        = ~en_i;
  assign halt       = therm | all_off;
  assign force_open = ovp_i | otp_lo_i;

  led_fm_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (pwm_clk_i),
    .rise_o (rise)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    led_fm_chan #(.TIMEOUT(TIMEOUT)) u_chan (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .clr_i        (clr),
      .halt_i       (halt),
      .rise_i       (rise),
      .at_target_i  (at_target_i[g]),
      .over_short_i (over_short_i[g]),
      .pwm_on_i     (pwm_on_i[g]),
      .force_open_i (force_open),
      .dis_o        (dis[g]),
      .kind_o       (kind[g]),
      .exp_short_o  (exp_short[g])
    );
    assign is_short[g] = dis[g] & (kind[g] == FLT_SHORT);
    assign is_open[g]  = dis[g] & (kind[g] == FLT_OPEN);
  end

  led_fm_supervisor #(.NUM_CH(NUM_CH), .ESC_CNT(ESC_CNT)) u_sup (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .otp_hi_i    (otp_hi_i),
    .exp_short_i (exp_short),
    .dis_mask_i  (dis),
    .therm_o     (therm),
    .all_off_o   (all_off)
  );

  assign ch_en_o      = (en_i & ~halt) ? ~dis : '0;
  assign boost_stop_o = ~en_i | halt;
  assign dis_mask_o   = dis;
  assign short_flt_o  = |is_short;
  assign open_flt_o   = |is_open;
  assign therm_sd_o   = therm;
endmodule

// File: rtl/led_fault_mgr_chk.sv
module led_fault_mgr_chk #(
  parameter int unsigned NUM_CH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              pwm_clk_i,
  input logic              otp_hi_i,
  input logic [NUM_CH-1:0] ch_en_o,
  input logic              boost_stop_o,
  input logic [NUM_CH-1:0] dis_mask_o,
  input logic              short_flt_o,
  input logic              open_flt_o,
  input logic              therm_sd_o
);
  assert_mask_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i)) |-> ((dis_mask_o & $past(dis_mask_o)) == $past(dis_mask_o)));

  assert_disable_on_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dis_mask_o & ~$past(dis_mask_o)) != '0) |-> ($past(pwm_clk_i) && !$past(pwm_clk_i, 2)));

  assert_no_enable_of_disabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_en_o & dis_mask_o) == '0);

  assert_stop_kills_all_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boost_stop_o |-> (ch_en_o == '0));

  assert_therm_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && otp_hi_i) |=> therm_sd_o);

  assert_therm_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && therm_sd_o) |=> therm_sd_o);

  assert_therm_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    therm_sd_o |-> boost_stop_o);

  assert_enable_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (dis_mask_o == '0 && !short_flt_o && !open_flt_o && !therm_sd_o));

  assert_flags_need_mask_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (short_flt_o || open_flt_o) |-> (dis_mask_o != '0));
endmodule

bind led_fault_mgr led_fault_mgr_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .pwm_clk_i    (pwm_clk_i),
  .otp_hi_i     (otp_hi_i),
  .ch_en_o      (ch_en_o),
  .boost_stop_o (boost_stop_o),
  .dis_mask_o   (dis_mask_o),
  .short_flt_o  (short_flt_o),
  .open_flt_o   (open_flt_o),
  .therm_sd_o   (therm_sd_o)
);

// File: tb/led_fault_mgr_tb.sv
module led_fault_mgr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  typedef struct packed {
    logic [7:0] pre;
    logic [7:0] at;
    logic [7:0] sh;
    logic [7:0] on;
    logic       ovp;
    logic       lo;
    logic [3:0] pulses;
    logic [7:0] mask;
    logic       sflt;
    logic       oflt;
  } vec_t;

  // pre-proven strings, fault inputs, dimming edges, expected result
  localparam vec_t TBL [9] = '{
    '{8'hFF, 8'hFF, 8'h00, 8'hFF, 1'b0, 1'b0, 4'd6, 8'h00, 1'b0, 1'b0}, // R1 healthy
    '{8'hFF, 8'hFE, 8'h00, 8'hFF, 1'b0, 1'b0, 4'd6, 8'h01, 1'b0, 1'b1}, // R2 open
    '{8'hFF, 8'hFE, 8'h00, 8'hFF, 1'b0, 1'b0, 4'd5, 8'h00, 1'b0, 1'b0}, // R3 one edge short
    '{8'hFF, 8'hFF, 8'h04, 8'hFF, 1'b0, 1'b0, 4'd6, 8'h04, 1'b1, 1'b0}, // R6 short
    '{8'h0F, 8'h0F, 8'h00, 8'hFF, 1'b1, 1'b0, 4'd6, 8'hF0, 1'b0, 1'b1}, // R5 overvoltage
    '{8'h3F, 8'h3F, 8'h00, 8'hFF, 1'b0, 1'b1, 4'd6, 8'hC0, 1'b0, 1'b1}, // R5 lower temp
    '{8'h0F, 8'h0F, 8'h00, 8'hFF, 1'b0, 1'b0, 4'd6, 8'h00, 1'b0, 1'b0}, // R1 unproven kept
    '{8'hFF, 8'hFD, 8'h01, 8'hFF, 1'b0, 1'b0, 4'd6, 8'h03, 1'b1, 1'b1}, // R11 both kinds
    '{8'hFF, 8'hFF, 8'h04, 8'hFB, 1'b0, 1'b0, 4'd6, 8'h00, 1'b0, 1'b0}  // R6 not driven
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, en_i = 1'b1, pwm_clk_i = 1'b0;
  logic [N-1:0] at_target_i = '1, over_short_i = '0, pwm_on_i = '1;
  logic ovp_i = 1'b0, otp_lo_i = 1'b0, otp_hi_i = 1'b0;
  logic [N-1:0] ch_en_o, dis_mask_o;
  logic boost_stop_o, short_flt_o, open_flt_o, therm_sd_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  led_fault_mgr u_dut (
    .clk_i, .rst_ni, .en_i, .pwm_clk_i, .at_target_i, .over_short_i, .pwm_on_i,
    .ovp_i, .otp_lo_i, .otp_hi_i, .ch_en_o, .boost_stop_o, .dis_mask_o,
    .short_flt_o, .open_flt_o, .therm_sd_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i) pwm_clk_i = 1'b1;
      @(negedge clk_i) pwm_clk_i = 1'b0;
    end
  endtask

  task automatic restart();
    @(negedge clk_i);
    en_i = 1'b0; at_target_i = '1; over_short_i = '0; pwm_on_i = '1;
    ovp_i = 1'b0; otp_lo_i = 1'b0; otp_hi_i = 1'b0;
    @(negedge clk_i);
    check("R10 off en", {31'd0, boost_stop_o}, 32'd1);
    check("R10 off ch_en", {24'd0, ch_en_o}, 32'd0);
    en_i = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    check("R10 reset mask", {24'd0, dis_mask_o}, 32'd0);
    check("R10 reset ch_en", {24'd0, ch_en_o}, 32'hFF);
    check("R10 reset stop", {31'd0, boost_stop_o}, 32'd0);
    check("R10 reset flags", {29'd0, short_flt_o, open_flt_o, therm_sd_o}, 32'd0);
    @(negedge clk_i) rst_ni = 1'b1;

    for (int t = 0; t < 9; t++) begin
      restart();
      at_target_i = TBL[t].pre; pwm_on_i = '1;
      @(negedge clk_i);
      at_target_i = TBL[t].at; over_short_i = TBL[t].sh; pwm_on_i = TBL[t].on;
      ovp_i = TBL[t].ovp; otp_lo_i = TBL[t].lo;
      @(negedge clk_i);
      ovp_i = 1'b0; otp_lo_i = 1'b0;
      pulses(int'(TBL[t].pulses));
      check($sformatf("R3 table %0d mask", t), {24'd0, dis_mask_o}, {24'd0, TBL[t].mask});
      check($sformatf("R11 table %0d short", t), {31'd0, short_flt_o}, {31'd0, TBL[t].sflt});
      check($sformatf("R11 table %0d open", t), {31'd0, open_flt_o}, {31'd0, TBL[t].oflt});
      check($sformatf("R9 table %0d ch_en", t), {24'd0, ch_en_o}, {24'd0, ~TBL[t].mask});
    end

    // R4: fault removed part-way restarts the count
    restart();
    @(negedge clk_i) at_target_i = 8'hFE;
    pulses(3);
    at_target_i = 8'hFF;
    @(negedge clk_i);
    @(negedge clk_i) at_target_i = 8'hFE;
    @(negedge clk_i);
    pulses(5);
    check("R4 count restarted", {24'd0, dis_mask_o}, 32'h00);
    pulses(1);
    check("R4 expiry after restart", {24'd0, dis_mask_o}, 32'h01);

    // R7: two already off, two shorts expire together: no shutdown
    restart();
    @(negedge clk_i) at_target_i = 8'hFC;
    @(negedge clk_i);
    pulses(6);
    check("R7 two open", {24'd0, dis_mask_o}, 32'h03);
    at_target_i = 8'hFF; over_short_i = 8'h30;
    @(negedge clk_i);
    pulses(6);
    check("R7 joint expiry mask", {24'd0, dis_mask_o}, 32'h33);
    check("R7 joint expiry ch_en", {24'd0, ch_en_o}, 32'hCC);
    check("R7 joint expiry stop", {31'd0, boost_stop_o}, 32'd0);

    // R7: three already off, one short expires: all off
    restart();
    @(negedge clk_i) at_target_i = 8'hF8;
    @(negedge clk_i);
    pulses(6);
    check("R7 three open", {24'd0, dis_mask_o}, 32'h07);
    at_target_i = 8'hFF; over_short_i = 8'h20;
    @(negedge clk_i);
    pulses(5);
    check("R7 before escalation", {24'd0, ch_en_o}, 32'hF8);
    pulses(1);
    check("R7 escalation ch_en", {24'd0, ch_en_o}, 32'h00);
    check("R7 escalation stop", {31'd0, boost_stop_o}, 32'd1);
    check("R7 escalation mask", {24'd0, dis_mask_o}, 32'h27);

    // R8: upper temperature latch, cleared only by enable
    restart();
    @(negedge clk_i) otp_hi_i = 1'b1;
    @(negedge clk_i) otp_hi_i = 1'b0;
    check("R8 therm set", {31'd0, therm_sd_o}, 32'd1);
    check("R8 therm stop", {31'd0, boost_stop_o}, 32'd1);
    repeat (5) @(negedge clk_i);
    check("R8 therm held", {31'd0, therm_sd_o}, 32'd1);
    check("R8 therm ch_en", {24'd0, ch_en_o}, 32'h00);
    restart();
    @(negedge clk_i);
    check("R10 cleared therm", {31'd0, therm_sd_o}, 32'd0);
    check("R10 cleared ch_en", {24'd0, ch_en_o}, 32'hFF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule